// File: doc/BRIEF.md
# Page Write Controller with Status Readback

This block is the synchronous write front end of a byte-wide non-volatile memory. A host issues byte write strobes, each with an address and a data byte. The block collects them in a page buffer. The upper address bits name the page and the lower bits name the byte within it. A load timer restarts on every accepted byte. When the timer runs out with no further strobe, the internal programming phase begins. During that phase the buffered bytes are sent one per cycle to an array write port, and the block stays busy for a modelled program time.

While a load is open, after an aborted load, and throughout programming, host reads return a status byte in place of array contents. The status byte carries:
- an inverted copy of the top data bit;
- a bit that toggles on each read;
- a load-timer-expired bit;
- a page-abort flag;
- the protection state supplied on an input.

If a byte arrives for a different page while a load is open, that byte is dropped, the buffer is emptied and no programming happens.

Both program durations must be at least one page long in cycles. This lets the drain of the buffer finish inside the busy period.

Top module: `page_write_ctrl`

## Requirements
- R1: A write strobe while idle or aborted opens a load. It records addr[ADDR_W-1:OFF_W] as the page and stores wrData at offset addr[OFF_W-1:0]. After programming, an idle read of that address returns the byte.
- R2: Programming starts after LOAD_WIN consecutive clock edges with no write strobe following the last accepted byte. Each accepted same-page strobe restarts this count.
- R3: A strobe during a load whose page differs from the recorded page is handled as an abort:
  - the strobe is discarded, the buffer is emptied and no programming follows;
  - status bit 1 then reads 1 until the next strobe opens a new load, which clears it to 0.
- R4: While a load is open, after an abort, or during programming, a read returns a status byte:
  - bits 4..2 read 0;
  - bit 0 equals protectIn;
  - bit 5 reads 1 only during programming.
- R5: Status bit 7 is the inverse of bit 7 of the last byte accepted into the load. After an abort it reads 1.
- R6: Status bit 6 is 0 on the first status read after a load opens. It inverts on every later status read.
- R7: rdData is registered. It updates one cycle after rdStb and otherwise holds. An idle read returns arrRdData. After reset it is 0.
- R8: busy stays high for BYTE_CYC cycles when exactly one strobe was accepted, and for PAGE_CYC cycles otherwise. donePulse is high only in the last busy cycle.
- R9: Write strobes while busy are ignored. They do not change the buffer or the array.
- R10: In busy cycle i (counting from 0, i < 2^OFF_W), arrWrEn is high exactly when offset i was loaded. arrWrAddr is {page, i} and arrWrData is the last byte written to that offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrStb | input | 1 | Host byte write strobe |
| rdStb | input | 1 | Host read strobe |
| addr | input | ADDR_W | Host byte address |
| wrData | input | 8 | Host write data |
| protectIn | input | 1 | Protection state reported in status bit 0 |
| arrRdData | input | 8 | Array contents at addr |
| rdData | output | 8 | Registered read result |
| busy | output | 1 | Internal programming in progress |
| donePulse | output | 1 | Last cycle of programming |
| arrWrEn | output | 1 | Array byte write enable |
| arrWrAddr | output | ADDR_W | Array byte write address |
| arrWrData | output | 8 | Array byte write data |

## Verification
The bench places a strobe on the last edge the window allows, and checks that busy is still low one cycle before the window ends.
- A timer that ran off by one edge would start programming one cycle early or late.

A page change mid-load must leave the array untouched and report bit 1 until the next load.
- A design that kept the discarded byte, or programmed the partial page, would change memory the bench expects to hold 0xFF.

A repeated offset must leave only its last byte in the array.

A write during busy must not reach the array.

Toggle phase and inverted polling are compared on every read, so a toggle not reset at load start shows up at once.

// File: rtl/pwc_pkg.sv
`timescale 1ns/1ps
package pwc_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_PROG  = 2'd2,
    ST_ABORT = 2'd3
  } pwcState_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic storeByte;      // write wrData into the buffer at the addressed offset
    logic clearBuf;       // empty valid mask, reset drain index and polling bit
    logic restartToggle;  // new load: toggle bit back to 0
    logic progPhase;      // internal programming active
    logic statusMode;     // reads return the status byte
  } pwcStrobe_t;
endpackage

// File: rtl/pwc_ctrl.sv
`timescale 1ns/1ps
module pwc_ctrl
  import pwc_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int OFF_W    = 7,
  parameter int LOAD_WIN = 18750,
  parameter int BYTE_CYC = 625000,
  parameter int PAGE_CYC = 1250000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wrStb,
  input  logic [ADDR_W-1:0]       addr,
  output pwcStrobe_t              strb,
  output logic [ADDR_W-OFF_W-1:0] pageOut,
  output logic                    abortFlag,
  output logic                    busy,
  output logic                    donePulse
);
  localparam int PAGE_W  = ADDR_W - OFF_W;
  localparam int MAX_A   = (LOAD_WIN > BYTE_CYC) ? LOAD_WIN : BYTE_CYC;
  localparam int MAX_CYC = (MAX_A > PAGE_CYC) ? MAX_A : PAGE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] WIN_M1  = CNT_W'(LOAD_WIN - 1);
  localparam logic [CNT_W-1:0] BYTE_M1 = CNT_W'(BYTE_CYC - 1);
  localparam logic [CNT_W-1:0] PAGE_M1 = CNT_W'(PAGE_CYC - 1);

  pwcState_e         state;
  logic [CNT_W-1:0]  loadCnt;
  logic [CNT_W-1:0]  progCnt;
  logic [PAGE_W-1:0] pageReg;
  logic              multiByte;

  logic pageHit, startLoad, moreLoad, abortNow, progEnd;

  always_comb begin
    pageHit   = (addr[ADDR_W-1:OFF_W] == pageReg);
    startLoad = wrStb && ((state == ST_IDLE) || (state == ST_ABORT));
    moreLoad  = wrStb && (state == ST_LOAD) && pageHit;
    abortNow  = wrStb && (state == ST_LOAD) && !pageHit;
    progEnd   = (state == ST_PROG) && (progCnt == '0);

    strb.storeByte     = startLoad || moreLoad;
    strb.clearBuf      = startLoad || abortNow || progEnd;
    strb.restartToggle = startLoad;
    strb.progPhase     = (state == ST_PROG);
    strb.statusMode    = (state != ST_IDLE);
  end

  assign pageOut   = pageReg;
  assign busy      = (state == ST_PROG);
  assign donePulse = progEnd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      loadCnt   <= '0;
      progCnt   <= '0;
      pageReg   <= '0;
      multiByte <= 1'b0;
      abortFlag <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_ABORT: begin
          if (wrStb) begin
            state     <= ST_LOAD;
            pageReg   <= addr[ADDR_W-1:OFF_W];
            loadCnt   <= WIN_M1;
            multiByte <= 1'b0;
            abortFlag <= 1'b0;
          end
        end
        ST_LOAD: begin
          if (wrStb) begin
            if (pageHit) begin
              loadCnt   <= WIN_M1;
              multiByte <= 1'b1;
            end else begin
              state     <= ST_ABORT;
              abortFlag <= 1'b1;
            end
          end else if (loadCnt == '0) begin
            state   <= ST_PROG;
            progCnt <= multiByte ? PAGE_M1 : BYTE_M1;
          end else begin
            loadCnt <= loadCnt - 1'b1;
          end
        end
        ST_PROG: begin
          if (progCnt == '0) state <= ST_IDLE;
          else               progCnt <= progCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwc_datapath.sv
`timescale 1ns/1ps
module pwc_datapath
  import pwc_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int OFF_W  = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  pwcStrobe_t              strb,
  input  logic [OFF_W-1:0]        addrOff,
  input  logic [BYTE_W-1:0]       wrData,
  input  logic                    rdStb,
  input  logic [BYTE_W-1:0]       arrRdData,
  input  logic                    protectIn,
  input  logic                    abortFlag,
  input  logic [ADDR_W-OFF_W-1:0] pageIn,
  output logic [BYTE_W-1:0]       rdData,
  output logic                    arrWrEn,
  output logic [ADDR_W-1:0]       arrWrAddr,
  output logic [BYTE_W-1:0]       arrWrData
);
  localparam int PAGE = 1 << OFF_W;

  logic [BYTE_W-1:0] pageBuf [PAGE];
  logic [PAGE-1:0]   validMask;
  logic [OFF_W:0]    drainIdx;
  logic              lastBit7;
  logic              toggleBit;

  logic [OFF_W-1:0]  drainOff;
  logic              drainLive;
  logic [BYTE_W-1:0] statusByte;

  always_ff @(posedge clk) begin
    if (strb.storeByte) pageBuf[addrOff] <= wrData;
  end

  for (genvar i = 0; i < PAGE; i++) begin : g_valid
    always_ff @(posedge clk) begin
      if (!rst_n)
        validMask[i] <= 1'b0;
      else if (strb.storeByte && (addrOff == OFF_W'(i)))
        validMask[i] <= 1'b1;
      else if (strb.clearBuf)
        validMask[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drainIdx <= '0;
    end else if (strb.clearBuf) begin
      drainIdx <= '0;
    end else if (strb.progPhase && !drainIdx[OFF_W]) begin
      drainIdx <= drainIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lastBit7 <= 1'b0;
    end else if (strb.storeByte) begin
      lastBit7 <= wrData[BYTE_W-1];
    end else if (strb.clearBuf && !strb.progPhase) begin
      lastBit7 <= 1'b0;
    end
  end

  always_comb begin
    drainOff   = drainIdx[OFF_W-1:0];
    drainLive  = strb.progPhase && !drainIdx[OFF_W];
    arrWrEn    = drainLive && validMask[drainOff];
    arrWrAddr  = {pageIn, drainOff};
    arrWrData  = pageBuf[drainOff];
    statusByte = {~lastBit7, toggleBit, strb.progPhase, 3'b000, abortFlag, protectIn};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      toggleBit <= 1'b0;
      rdData    <= '0;
    end else begin
      if (strb.restartToggle) toggleBit <= 1'b0;
      else if (rdStb && strb.statusMode) toggleBit <= ~toggleBit;
      if (rdStb) rdData <= strb.statusMode ? statusByte : arrRdData;
    end
  end
endmodule

// File: rtl/page_write_ctrl.sv
`timescale 1ns/1ps
module page_write_ctrl
  import pwc_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int OFF_W    = 7,
  parameter int LOAD_WIN = 18750,
  parameter int BYTE_CYC = 625000,
  parameter int PAGE_CYC = 1250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrStb,
  input  logic              rdStb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              protectIn,
  input  logic [7:0]        arrRdData,
  output logic [7:0]        rdData,
  output logic              busy,
  output logic              donePulse,
  output logic              arrWrEn,
  output logic [ADDR_W-1:0] arrWrAddr,
  output logic [7:0]        arrWrData
);
  pwcStrobe_t              strb;
  logic [ADDR_W-OFF_W-1:0] pageCur;
  logic                    abortFlag;

  pwc_ctrl #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LOAD_WIN(LOAD_WIN),
    .BYTE_CYC(BYTE_CYC), .PAGE_CYC(PAGE_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrStb(wrStb), .addr(addr),
    .strb(strb), .pageOut(pageCur), .abortFlag(abortFlag),
    .busy(busy), .donePulse(donePulse)
  );

  pwc_datapath #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .addrOff(addr[OFF_W-1:0]),
    .wrData(wrData), .rdStb(rdStb), .arrRdData(arrRdData),
    .protectIn(protectIn), .abortFlag(abortFlag), .pageIn(pageCur),
    .rdData(rdData), .arrWrEn(arrWrEn), .arrWrAddr(arrWrAddr),
    .arrWrData(arrWrData)
  );
endmodule

// File: rtl/page_write_ctrl_chk.sv
`timescale 1ns/1ps
module page_write_ctrl_chk #(
  parameter int ADDR_W = 17,
  parameter int OFF_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rdStb,
  input logic [7:0]        rdData,
  input logic              busy,
  input logic              donePulse,
  input logic              arrWrEn,
  input logic [ADDR_W-1:0] arrWrAddr
);
  // R10
  wr_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arrWrEn |-> busy);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !donePulse) |=> busy);

  // R8
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    donePulse |=> !busy);

  // R4
  prog_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStb && busy) |=> (rdData[5] && (rdData[4:2] == 3'b000)));

  // R6
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStb && busy && $past(rdStb && busy)) |=> (rdData[6] != $past(rdData[6])));

  // R10
  drain_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arrWrEn && $past(arrWrEn)) |->
      (arrWrAddr[ADDR_W-1:OFF_W] == $past(arrWrAddr[ADDR_W-1:OFF_W])));
endmodule

bind page_write_ctrl page_write_ctrl_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rdStb(rdStb), .rdData(rdData), .busy(busy),
  .donePulse(donePulse), .arrWrEn(arrWrEn), .arrWrAddr(arrWrAddr)
);

// File: tb/page_write_ctrl_tb.sv
`timescale 1ns/1ps
module page_write_ctrl_tb;
  localparam int ADDR_W = 17;
  localparam int OFF_W  = 7;
  localparam int W      = 20;
  localparam int BC     = 200;
  localparam int PC     = 400;

  logic clk = 1'b0;
  logic rst_n;
  logic wrStb, rdStb, protectIn;
  logic [ADDR_W-1:0] addr;
  logic [7:0] wrData, arrRdData;
  logic [7:0] rdData;
  logic busy, donePulse, arrWrEn;
  logic [ADDR_W-1:0] arrWrAddr;
  logic [7:0] arrWrData;

  always #4 clk = ~clk;

  page_write_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LOAD_WIN(W),
                    .BYTE_CYC(BC), .PAGE_CYC(PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .wrStb(wrStb), .rdStb(rdStb), .addr(addr),
    .wrData(wrData), .protectIn(protectIn), .arrRdData(arrRdData),
    .rdData(rdData), .busy(busy), .donePulse(donePulse), .arrWrEn(arrWrEn),
    .arrWrAddr(arrWrAddr), .arrWrData(arrWrData));

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model: 0 idle, 1 loading, 2 programming, 3 aborted
  int mState, mIdle, mPage, mCount, mEl, mDur;
  logic [7:0] mBuf [0:127];
  bit   mValid [0:127];
  bit   mLast7, mToggle, mAbort;
  logic [7:0] mRd;
  logic [7:0] mem [int];

  function automatic logic [7:0] memRd(input int a);
    if (mem.exists(a)) return mem[a];
    return 8'hFF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mState = 0; mIdle = 0; mPage = 0; mCount = 0; mEl = 0; mDur = 0;
      mLast7 = 0; mToggle = 0; mAbort = 0; mRd = 8'h00;
      foreach (mValid[i]) mValid[i] = 0;
    end else begin
      if (rdStb) begin
        if (mState != 0) begin
          mRd = {~mLast7, mToggle, (mState == 2), 3'b000, mAbort, protectIn};
          mToggle = ~mToggle;
        end else mRd = memRd(int'(addr));
      end
      if (mState == 2 && mEl < 128 && mValid[mEl]) mem[mPage * 128 + mEl] = mBuf[mEl];
      case (mState)
        0, 3: if (wrStb) begin
          mState = 1; mPage = int'(addr) / 128;
          foreach (mValid[i]) mValid[i] = 0;
          mValid[int'(addr) % 128] = 1; mBuf[int'(addr) % 128] = wrData;
          mCount = 1; mLast7 = wrData[7]; mToggle = 0; mAbort = 0; mIdle = 0;
        end
        1: if (wrStb) begin
          if (int'(addr) / 128 == mPage) begin
            mValid[int'(addr) % 128] = 1; mBuf[int'(addr) % 128] = wrData;
            mCount++; mLast7 = wrData[7]; mIdle = 0;
          end else begin
            mState = 3; mAbort = 1; mCount = 0; mLast7 = 0;
            foreach (mValid[i]) mValid[i] = 0;
          end
        end else begin
          mIdle++;
          if (mIdle == W) begin
            mState = 2; mEl = 0; mDur = (mCount == 1) ? BC : PC;
          end
        end
        2: if (mEl == mDur - 1) begin
          mState = 0; foreach (mValid[i]) mValid[i] = 0;
        end else mEl++;
        default: mState = 0;
      endcase
    end
  end

  // compare with the model on every clock
  int cyc = 0;
  int bStart = 0;
  int lastDur = 0;
  bit pBusy = 0;
  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    if (rst_n) begin
      bit eBusy, eDone, eWr;
      eBusy = (mState == 2);
      eDone = (mState == 2) && (mEl == mDur - 1);
      eWr   = (mState == 2) && (mEl < 128) && mValid[mEl];
      chk(busy == eBusy, "R8 busy", busy, eBusy);
      chk(donePulse == eDone, "R8 done", donePulse, eDone);
      chk(arrWrEn == eWr, "R10 wren", arrWrEn, eWr);
      if (eWr) begin
        chk(int'(arrWrAddr) == mPage * 128 + mEl, "R10 waddr", arrWrAddr, mPage * 128 + mEl);
        chk(arrWrData == mBuf[mEl], "R10 wdata", arrWrData, mBuf[mEl]);
      end
      chk(rdData == mRd, "R4 R5 R6 R7 rddata", rdData, mRd);
      if (busy && !pBusy) bStart = cyc;
      if (!busy && pBusy) lastDur = cyc - bStart;
      pBusy = busy;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doWrite(input int a, input logic [7:0] d);
    addr = ADDR_W'(a); wrData = d; wrStb = 1'b1; arrRdData = memRd(a);
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic doRead(input int a, output logic [7:0] r);
    addr = ADDR_W'(a); rdStb = 1'b1; arrRdData = memRd(a);
    @(negedge clk);
    rdStb = 1'b0;
    r = rdData;
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 5000 && !busy; k++) @(negedge clk);
    for (int k = 0; k < 5000 && busy; k++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    wrStb = 0; rdStb = 0; addr = '0; wrData = 0; protectIn = 0; arrRdData = 8'hFF;
    rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0, "R8 reset busy", busy, 0);
    chk(rdData == 0, "R7 reset rddata", rdData, 0);
    chk(arrWrEn == 0, "R10 reset wren", arrWrEn, 0);

    // single byte, status during load and programming
    doWrite(261, 8'hA5);
    doRead(261, r); chk(r == 8'h00, "R4 load status", r, 8'h00);
    doRead(261, r); chk(r == 8'h40, "R6 toggle", r, 8'h40);
    tick(W - 3); chk(busy == 0, "R2 window open", busy, 0);
    tick(1);     chk(busy == 1, "R2 window expired", busy, 1);
    doRead(0, r); chk(r == 8'h20, "R5 inverted poll", r, 8'h20);
    waitIdle();
    chk(lastDur == BC, "R8 byte duration", lastDur, BC);
    doRead(261, r); chk(r == 8'hA5, "R1 readback", r, 8'hA5);

    // multi-byte page with a strobe at the window edge and a repeated offset
    doWrite(384, 8'h11);
    doWrite(385, 8'h92);
    tick(W - 1);
    doWrite(511, 8'h7E);
    tick(W - 1); chk(busy == 0, "R2 restart", busy, 0);
    doWrite(385, 8'h33);
    tick(W); chk(busy == 1, "R2 page start", busy, 1);
    doWrite(394, 8'h55);
    doRead(384, r); chk(r[7] == 1'b1, "R5 poll bit", r[7], 1);
    chk(r[5] == 1'b1, "R4 timer bit", r[5], 1);
    waitIdle();
    chk(lastDur == PC, "R8 page duration", lastDur, PC);
    doRead(384, r); chk(r == 8'h11, "R10 offset0", r, 8'h11);
    doRead(385, r); chk(r == 8'h33, "R10 last wins", r, 8'h33);
    doRead(511, r); chk(r == 8'h7E, "R10 top offset", r, 8'h7E);
    doRead(386, r); chk(r == 8'hFF, "R10 unloaded", r, 8'hFF);
    doRead(394, r); chk(r == 8'hFF, "R9 busy write ignored", r, 8'hFF);

    // page change abort
    protectIn = 1;
    doWrite(512, 8'h80);
    doWrite(640, 8'h01);
    doRead(512, r); chk(r == 8'h83, "R3 abort status", r, 8'h83);
    tick(3 * W); chk(busy == 0, "R3 no program", busy, 0);
    doRead(512, r); chk(r[1] == 1'b1, "R3 flag holds", r[1], 1);
    chk(r[0] == 1'b1, "R4 protect bit", r[0], 1);
    doWrite(770, 8'h44);
    doRead(770, r); chk(r == 8'h81, "R3 flag cleared", r, 8'h81);
    waitIdle();
    chk(lastDur == BC, "R8 byte duration 2", lastDur, BC);
    protectIn = 0;
    doRead(770, r); chk(r == 8'h44, "R1 new load", r, 8'h44);
    doRead(512, r); chk(r == 8'hFF, "R3 first byte dropped", r, 8'hFF);
    doRead(640, r); chk(r == 8'hFF, "R3 offending byte dropped", r, 8'hFF);
    tick(3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule